// File: doc/BRIEF.md
# Per-Hart Machine Timer Comparator

This block keeps one free-running 64-bit time count shared by a small group of harts. It holds a 64-bit compare value for each hart and drives one timer interrupt line per hart. A hart's line is a level: it is high while the time count has reached or passed that hart's compare value.

Software reaches the block over a simple 32-bit register bus. Each transfer has a request strobe, a write flag, an address and write data. Read data comes back on the cycle after the request, together with a valid flag. Each 64-bit register is reached as two 32-bit words in little-endian order, so the low word sits at the lower address.

The time count cannot be written. It advances by one on every clock cycle in which the tick-enable input is high. Interrupt lines are re-evaluated on every cycle, so a compare value written below the present time raises its line at once.

Top module: `hart_timer_unit`

## Requirements
- R1: After reset every compare register holds zero and the time count holds the parameter `TIME_RST` (default zero). Every `timer_irq` bit is therefore high.
- R2: The time count rises by exactly one on each clock edge where `tick_en` is high. It holds its value when `tick_en` is low. It wraps from 2^64-1 to 0.
- R3: A write to the low word of a compare register replaces bits 31:0 with the write data and leaves bits 63:32 unchanged.
- R4: A write to the high word of a compare register replaces bits 63:32 with the write data and leaves bits 31:0 unchanged.
- R5: After every clock edge, `timer_irq[h]` equals (time >= compare[h]), using the values the registers took at that edge. A compare value at or below the time count raises the line in the cycle that follows the write.
- R6: A read at address `TIME_BASE` returns time bits 31:0, and a read at `TIME_BASE`+4 returns bits 63:32. Every read returns its data on `bus_rdata` with `bus_rvalid` high on the cycle after the request. `bus_rvalid` is low after writes and idle cycles.
- R7: Writes to either time word change nothing. The time count read back afterwards follows R2 alone.
- R8: Reads return zero at the following addresses, and writes there change no register:
  - addresses whose bits 1:0 are not zero;
  - addresses in neither the compare window nor the two time words;
  - compare slots whose hart index is `NUM_HARTS` or above.
- R9: Hart h's compare register has its low word at `CMP_BASE`+8h and its high word at `CMP_BASE`+8h+4. Address bit 2 selects the word, because both bases are 8-byte aligned. A write to one hart's register leaves every other hart's register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Advances the time count by one when high |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | High on the cycle after a read request |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
The bench runs the time count across the 2^64 wrap. A design that drops the carry would show a wrong high word and a stale interrupt level. Word-merge writes are read back in both orders: a design that zeroes or overwrites the other half of a compare register reports the wrong word. Compare values are placed just below, at, and just above the running time. This catches a design that compares with a strict inequality, fires one cycle late, or only raises the line when the time count moves past the value. Accesses to the hart slot one past the last, to misaligned offsets and to the time words are checked for zero reads or no effect. This catches an index decode that aliases or a time count that accepts writes.

// File: rtl/htu_pkg.sv
package htu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TIME_W = 64;

  typedef logic [TIME_W-1:0] tval_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_CMP  = 2'd1,
    HIT_TIME = 2'd2
  } hit_e;
endpackage

// File: rtl/htu_rst_sync.sv
module htu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/htu_time_ctr.sv
module htu_time_ctr
  import htu_pkg::*;
#(
  parameter tval_t RST_VAL = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_en,
  output tval_t time_d,
  output tval_t time_q
);
  always_comb begin
    time_d = time_q;
    if (tick_en) time_d = time_q + tval_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= RST_VAL;
    else if (tick_en) time_q <= time_d;
  end

  // R2: one step per enabled cycle, wrapping modulo 2^64
  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> time_q == $past(time_q) + tval_t'(1));

  // R2 / R7: nothing but the enable moves the count
  a_r7_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(time_q));
endmodule

// File: rtl/htu_cmp_slot.sv
module htu_cmp_slot
  import htu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_lo,
  input  logic  wr_hi,
  input  word_t wdata,
  input  tval_t time_d,
  input  tval_t time_q,
  output tval_t cmp_q,
  output logic  irq_q
);
  tval_t cmp_d;
  logic  cmp_en;
  logic  irq_d;

  always_comb begin
    cmp_d = cmp_q;
    if (wr_lo) cmp_d[31:0]  = wdata;
    if (wr_hi) cmp_d[63:32] = wdata;
    cmp_en = wr_lo | wr_hi;
    irq_d  = (time_d >= cmp_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_en) cmp_q <= cmp_d;
  end

  // reset: compare zero, so any time value satisfies time >= compare
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b1;
    else        irq_q <= irq_d;
  end

  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (time_q >= cmp_q));

  a_r3_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> cmp_q[63:32] == $past(cmp_q[63:32]));

  a_r3_lo_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cmp_q[31:0] == $past(wdata));

  a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> cmp_q[31:0] == $past(cmp_q[31:0]));

  a_r4_hi_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> cmp_q[63:32] == $past(wdata));
endmodule

// File: rtl/htu_regif.sv
module htu_regif
  import htu_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 1,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CMP_BASE  = 32'h0000,
  parameter int unsigned TIME_BASE = 32'h7FF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  tval_t                time_q,
  input  tval_t                cmp_q [NUM_HARTS],
  output logic [NUM_HARTS-1:0] wr_lo,
  output logic [NUM_HARTS-1:0] wr_hi,
  output word_t                rdata_q,
  output logic                 rvalid_q
);
  localparam int unsigned IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
  localparam logic [ADDR_W-1:0] CMP_LO    = ADDR_W'(CMP_BASE);
  localparam logic [ADDR_W-1:0] CMP_END   = ADDR_W'(CMP_BASE + 8 * NUM_HARTS);
  localparam logic [ADDR_W-1:0] TIME_LO_A = ADDR_W'(TIME_BASE);
  localparam logic [ADDR_W-1:0] TIME_HI_A = ADDR_W'(TIME_BASE + 4);

  logic [ADDR_W-1:0] cmp_off;
  logic [IDX_W-1:0]  idx;
  logic              hi_word;
  hit_e              hit;
  tval_t             sel_cmp;
  word_t             rd_d;
  logic              rd_en;
  logic              wr_cmp;

  always_comb begin
    cmp_off = bus_addr - CMP_LO;
    idx     = IDX_W'(cmp_off >> 3);
    hi_word = bus_addr[2];
    hit     = HIT_NONE;
    if (bus_addr[1:0] == 2'b00 && bus_addr >= CMP_LO && bus_addr < CMP_END)
      hit = HIT_CMP;
    else if (bus_addr == TIME_LO_A || bus_addr == TIME_HI_A)
      hit = HIT_TIME;
  end

  always_comb begin
    sel_cmp = '0;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (idx == IDX_W'(h)) sel_cmp = cmp_q[h];
    end
  end

  always_comb begin
    case (hit)
      HIT_CMP:  rd_d = hi_word ? sel_cmp[63:32] : sel_cmp[31:0];
      HIT_TIME: rd_d = hi_word ? time_q[63:32]  : time_q[31:0];
      default:  rd_d = '0;
    endcase
    rd_en  = bus_req & ~bus_we;
    wr_cmp = bus_req & bus_we & (hit == HIT_CMP);
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_wr
    assign wr_lo[h] = wr_cmp & (idx == IDX_W'(h)) & ~hi_word;
    assign wr_hi[h] = wr_cmp & (idx == IDX_W'(h)) &  hi_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_d;
    end
  end

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit == HIT_NONE) |=> rdata_q == '0);

  a_r6_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid_q);

  a_r6_write_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |=> !rvalid_q);

  a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_lo, wr_hi}));
endmodule

// File: rtl/hart_timer_unit.sv
module hart_timer_unit
  import htu_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 1,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CMP_BASE  = 32'h0000,
  parameter int unsigned TIME_BASE = 32'h7FF8,
  parameter logic [63:0] TIME_RST  = 64'd0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  output logic [NUM_HARTS-1:0] timer_irq
);
  logic                 rst_n_core;
  tval_t                time_d;
  tval_t                time_q;
  tval_t                cmp_all [NUM_HARTS];
  logic [NUM_HARTS-1:0] wr_lo;
  logic [NUM_HARTS-1:0] wr_hi;

  htu_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_core)
  );

  htu_time_ctr #(.RST_VAL(TIME_RST)) u_time_ctr (
    .clk     (clk),
    .rst_n   (rst_n_core),
    .tick_en (tick_en),
    .time_d  (time_d),
    .time_q  (time_q)
  );

  htu_regif #(
    .NUM_HARTS (NUM_HARTS),
    .ADDR_W    (ADDR_W),
    .CMP_BASE  (CMP_BASE),
    .TIME_BASE (TIME_BASE)
  ) u_regif (
    .clk      (clk),
    .rst_n    (rst_n_core),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .time_q   (time_q),
    .cmp_q    (cmp_all),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .rdata_q  (bus_rdata),
    .rvalid_q (bus_rvalid)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
    htu_cmp_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_n_core),
      .wr_lo  (wr_lo[h]),
      .wr_hi  (wr_hi[h]),
      .wdata  (bus_wdata),
      .time_d (time_d),
      .time_q (time_q),
      .cmp_q  (cmp_all[h]),
      .irq_q  (timer_irq[h])
    );
  end
endmodule

// File: tb/hart_timer_unit_bench.sv
`timescale 1ns/1ps
module hart_timer_unit_bench;
  localparam int N  = 3;
  localparam int AW = 16;
  localparam int CB = 32'h0000;
  localparam int TB = 32'h7FF8;
  localparam logic [63:0] TR = 64'hFFFF_FFFF_FFFF_FFF0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_en;
  logic          bus_req;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [N-1:0]  timer_irq;

  hart_timer_unit #(
    .NUM_HARTS (N), .ADDR_W (AW), .CMP_BASE (CB), .TIME_BASE (TB), .TIME_RST (TR)
  ) u_hart_timer_unit (
    .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
    .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
    .timer_irq (timer_irq)
  );

  always #2.5 clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  int    cyc   = 0;
  bit    done  = 1'b0;
  bit    armed = 1'b0;
  string rd_tag = "R6";
  string pend_tag = "R6";

  // behavioural reference
  logic [63:0] m_time;
  logic [63:0] m_cmp [N];
  logic [31:0] exp_rd;
  bit          exp_pend;

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    int unsigned ia;
    int unsigned k;
    ia = a;
    m_read = 32'd0;
    if (ia % 4 == 0 && ia >= CB && ia < CB + 8 * N) begin
      k = (ia - CB) / 8;
      m_read = ((ia - CB) % 8 == 4) ? m_cmp[k][63:32] : m_cmp[k][31:0];
    end else if (ia == TB) begin
      m_read = m_time[31:0];
    end else if (ia == TB + 4) begin
      m_read = m_time[63:32];
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_time   <= TR;
      exp_pend <= 1'b0;
      for (int h = 0; h < N; h++) m_cmp[h] <= 64'd0;
    end else begin
      exp_pend <= 1'b0;
      if (bus_req && !bus_we) begin
        exp_rd   <= m_read(bus_addr);
        exp_pend <= 1'b1;
        pend_tag <= rd_tag;
      end
      if (bus_req && bus_we) begin
        int unsigned ia;
        int unsigned k;
        ia = bus_addr;
        if (ia % 4 == 0 && ia >= CB && ia < CB + 8 * N) begin
          k = (ia - CB) / 8;
          if ((ia - CB) % 8 == 4) m_cmp[k][63:32] <= bus_wdata;
          else                    m_cmp[k][31:0]  <= bus_wdata;
        end
      end
      if (tick_en) m_time <= m_time + 64'd1;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (armed && rst_n) begin
      for (int h = 0; h < N; h++)
        check("R5", 64'(timer_irq[h]), 64'(m_time >= m_cmp[h]));
      check("R6", 64'(bus_rvalid), 64'(exp_pend));
      if (exp_pend) check(pend_tag, 64'(bus_rdata), 64'(exp_rd));
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000 && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog all requirements actual=%0d cycles expected<60000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic bus_op(input logic w, input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = w; bus_addr = a; bus_wdata = d; rd_tag = tag;
  endtask

  task automatic bus_idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    armed = 1'b1;

    // R1: reset state
    check("R1", 64'(timer_irq), 64'(3'b111));
    bus_op(1'b0, AW'(CB), 32'h0, "R1");
    bus_op(1'b0, AW'(CB + 20), 32'h0, "R1");
    bus_op(1'b0, AW'(TB), 32'h0, "R1");
    bus_op(1'b0, AW'(TB + 4), 32'h0, "R6");
    bus_idle(1);
    check("R1", 64'(bus_rdata), 64'hFFFF_FFFF);

    // R7: time words reject writes
    bus_op(1'b1, AW'(TB), 32'h1234_5678, "R7");
    bus_op(1'b1, AW'(TB + 4), 32'h0000_0042, "R7");
    bus_op(1'b0, AW'(TB), 32'h0, "R7");
    bus_op(1'b0, AW'(TB + 4), 32'h0, "R7");
    bus_idle(1);
    check("R7", 64'(bus_rdata), 64'hFFFF_FFFF);

    // R2: run across the 2^64 wrap (0x...FFF0 + 20 = 4)
    tick_en = 1'b1;
    bus_idle(20);
    tick_en = 1'b0;
    bus_op(1'b0, AW'(TB + 4), 32'h0, "R2");
    bus_op(1'b0, AW'(TB), 32'h0, "R2");
    bus_idle(1);
    check("R2", 64'(bus_rdata), 64'd4);

    // R5: future value drops the line, R3/R4 word merges
    bus_op(1'b1, AW'(CB), 32'd100, "R5");
    bus_idle(1);
    check("R5", 64'(timer_irq[0]), 64'd0);
    bus_op(1'b1, AW'(CB + 4), 32'd1, "R4");
    bus_op(1'b0, AW'(CB), 32'h0, "R4");
    bus_idle(1);
    check("R4", 64'(bus_rdata), 64'd100);
    bus_op(1'b1, AW'(CB), 32'd0, "R3");
    bus_op(1'b0, AW'(CB + 4), 32'h0, "R3");
    bus_idle(1);
    check("R3", 64'(bus_rdata), 64'd1);

    // R5: compare equal to time fires, one above fires after one tick
    bus_op(1'b1, AW'(CB + 12), 32'd0, "R9");
    bus_op(1'b1, AW'(CB + 8), 32'd4, "R5");
    bus_idle(1);
    check("R5", 64'(timer_irq[1]), 64'd1);
    bus_op(1'b1, AW'(CB + 8), 32'd5, "R5");
    bus_idle(1);
    check("R5", 64'(timer_irq[1]), 64'd0);
    tick_en = 1'b1;
    bus_idle(1);
    tick_en = 1'b0;
    bus_idle(1);
    check("R5", 64'(timer_irq[1]), 64'd1);

    // R8: out-of-range hart, misaligned and unmapped addresses
    bus_op(1'b1, AW'(CB + 24), 32'hDEAD_BEEF, "R8");
    bus_op(1'b1, AW'(CB + 10), 32'hDEAD_BEEF, "R8");
    bus_op(1'b0, AW'(CB + 24), 32'h0, "R8");
    bus_op(1'b0, AW'(CB + 2), 32'h0, "R8");
    bus_op(1'b0, AW'(16'h1000), 32'h0, "R8");
    bus_op(1'b0, AW'(CB + 12), 32'h0, "R8");
    bus_op(1'b0, AW'(CB + 8), 32'h0, "R8");
    bus_idle(1);
    check("R8", 64'(bus_rdata), 64'd5);

    // R9: per-hart placement and independence
    bus_op(1'b1, AW'(CB + 16), 32'hA5A5_0001, "R9");
    bus_op(1'b1, AW'(CB + 20), 32'h0000_0007, "R9");
    bus_op(1'b0, AW'(CB + 16), 32'h0, "R9");
    bus_op(1'b0, AW'(CB + 20), 32'h0, "R9");
    bus_op(1'b0, AW'(CB + 4), 32'h0, "R9");
    bus_idle(1);
    check("R9", 64'(bus_rdata), 64'd1);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int unsigned op;
      int unsigned slot;
      logic [AW-1:0] a;
      logic [31:0] d;
      @(negedge clk);
      tick_en = ($urandom_range(0, 2) != 0);
      op   = $urandom_range(0, 9);
      slot = $urandom_range(0, 10);
      if (slot < 8)       a = AW'(CB + 4 * slot);
      else if (slot == 8) a = AW'(TB);
      else if (slot == 9) a = AW'(TB + 4);
      else                a = AW'(CB + 6);
      if (a[2]) d = m_time[63:32] + 32'($urandom_range(0, 2)) - 32'd1;
      else      d = m_time[31:0] + 32'($urandom_range(0, 8)) - 32'd4;
      if (op < 4) begin
        bus_req = 1'b0; bus_we = 1'b0;
      end else begin
        bus_req = 1'b1; bus_we = (op >= 7); bus_addr = a; bus_wdata = d;
        rd_tag = "R9";
      end
    end
    tick_en = 1'b0;
    bus_idle(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule